// File: doc/BRIEF.md
# SPI controller frame sequencer

This block is the serial engine of an SPI controller. It takes words from a transmit source over a valid/ready handshake, shifts each word out on PICO most significant bit first while shifting the same number of bits in from POCI, and offers every received word on a valid/ready output. All four combinations of clock polarity (`cpol_i`) and clock phase (`cpha_i`) are supported. The SCLK rate is set by `div_i`: one half period of SCLK lasts `div_i + 1` cycles of `clk_i` (written H below).

The sequencer owns chip-select timing. CS falls when a frame starts and rises one SCLK period (2H) after the last capture edge. Between two frames CS stays high for at least one SCLK period, except that in phase 1 with the continuous option (`b2b_i`) set, CS is held low across consecutive words. In phase 0 the continuous option has no effect, because CS always pulses high between words. In 3-wire mode the select output is held low at all times and frame timing is unchanged. `busy_o` marks the span from CS fall to the end of the CS hold.

Top module: `spi_frame_seq`

## Requirements
- R1: While no frame is running, SCLK rests at `cpol_i`: it is low for 0 and high for 1.
- R2: A frame starts only if `en_i` and `tx_valid_i` are both 1. While `en_i` is 0, `tx_ready_o` stays 0 and no frame starts.
- R3: Counted from the clock edge where CS falls, the first SCLK edge comes 2H cycles later in phase 0 and H cycles later in phase 1.
- R4: Words are sent and received MSB first. The captured bits are taken as follows: on odd-numbered SCLK edges of a word in phase 0, and on even-numbered edges in phase 1. PICO is stable at every capture edge, and POCI is sampled there.
- R5: CS rises exactly 2H cycles after the last capture edge of a frame.
- R6: In phase 0, consecutive words each get their own CS low period. CS stays high for 2H+1 cycles between them.
- R7: In phase 1 with `b2b_i` = 1 and the next word already valid, CS stays low from the first word to the end of the last. With `b2b_i` = 0, every word gets its own CS low period.
- R8: With `three_wire_i` = 1, `cs_no` is held low. Data transfer is the same as in 4-wire mode.
- R9: Each word produces exactly 2×DATA_W SCLK edges. PICO changes only while a frame runs.
- R10: `rx_valid_o` rises on the same clock edge as the last capture edge of a word, carrying that word. It stays high, with stable data, until `rx_ready_i` is 1.
- R11: `busy_o` rises on the edge where CS falls and falls on the edge where CS rises. It is high for (2×DATA_W+2)·H cycles for a single word.
- R12: The half period H equals `div_i` + 1 cycles of `clk_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables the start of new frames |
| cpol_i | input | 1 | SCLK idle level |
| cpha_i | input | 1 | 0: capture on first edge of a bit; 1: capture on second edge |
| three_wire_i | input | 1 | 1: select output held low |
| b2b_i | input | 1 | Keep CS low across words (phase 1 only) |
| div_i | input | DIV_W | Half period of SCLK minus one, in clock cycles |
| tx_data_i | input | DATA_W | Word to send |
| tx_valid_i | input | 1 | Transmit word available |
| tx_ready_o | output | 1 | Transmit word taken on this edge |
| rx_data_o | output | DATA_W | Received word |
| rx_valid_o | output | 1 | Received word available |
| rx_ready_i | input | 1 | Received word consumed |
| poci_i | input | 1 | Serial data from peripheral |
| sclk_o | output | 1 | Serial clock |
| pico_o | output | 1 | Serial data to peripheral |
| cs_no | output | 1 | Chip select, active low |
| busy_o | output | 1 | Frame in progress |

## Verification
A peripheral model in the bench shifts its own word out and takes PICO in on the edges that each phase defines. A single word is sent in all four polarity/phase modes: a wrong capture or launch edge then shows up as a shifted or corrupted word, and the first-edge and hold delays separate phase 0 from phase 1. A slower divider setting separates a fixed delay from one that scales with H. Three-word runs in phase 0, in phase 1 with the continuous option, and in phase 1 without it tell the pulsing CS apart from the held-low CS by counting CS falls and measuring the high time. 3-wire mode, a disabled block with valid data waiting, and a stalled receive side cover the select override, the start condition, and the holding of received data.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         launch_i,
  input  logic         capture_i,
  input  logic         poci_i,
  output logic         tx_bit_o,
  output logic [W-1:0] rx_next_o
);
  logic [W-1:0] tx_q, rx_q;

  assign tx_bit_o  = tx_q[W-1];
  assign rx_next_o = {rx_q[W-2:0], poci_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)        tx_q <= load_data_i;
      else if (launch_i) tx_q <= {tx_q[W-2:0], 1'b0};
      if (capture_i)     rx_q <= rx_next_o;
    end
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              three_wire_i,
  input  logic              b2b_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  input  logic              poci_i,
  output logic              sclk_o,
  output logic              pico_o,
  output logic              cs_no,
  output logic              busy_o
);
  // k counts half periods since CS fall: odd k launch, even k capture
  localparam int unsigned KW = $clog2(2 * DATA_W + 3);
  localparam logic [KW-1:0] K_TWO      = KW'(2);
  localparam logic [KW-1:0] K_LAST_LCH = KW'(2 * DATA_W - 1);
  localparam logic [KW-1:0] K_LAST_CAP = KW'(2 * DATA_W);
  localparam logic [KW-1:0] K_PH0_END  = KW'(2 * DATA_W + 1);
  localparam logic [KW-1:0] K_DONE     = KW'(2 * DATA_W + 2);

  seq_st_e st_q, st_d;
  logic [KW-1:0] k_q, k_d, knext;
  logic tick, run_tick, start, launch, capture, last_cap, cont, toggle, done;
  logic tx_bit;
  logic [DATA_W-1:0] rx_next, rx_data_q;
  logic cs_q, sclk_q, pico_q, rx_valid_q;

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != ST_IDLE),
    .div_i  (div_i),
    .tick_o (tick)
  );

  assign knext    = k_q + 1'b1;
  assign run_tick = (st_q == ST_RUN) && tick;
  assign start    = (st_q == ST_IDLE) && en_i && tx_valid_i;
  assign launch   = run_tick && knext[0] && (knext <= K_LAST_LCH);
  assign capture  = run_tick && !knext[0] && (knext <= K_LAST_CAP);
  assign last_cap = capture && (knext == K_LAST_CAP);
  assign cont     = last_cap && cpha_i && b2b_i && en_i && tx_valid_i;
  assign done     = run_tick && (knext == K_DONE);
  assign toggle   = run_tick && (cpha_i ? (knext <= K_LAST_CAP)
                                        : ((knext >= K_TWO) && (knext <= K_PH0_END)));

  assign tx_ready_o = ((st_q == ST_IDLE) && en_i) ||
                      (last_cap && cpha_i && b2b_i && en_i);

  spi_shifter #(.W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start || cont),
    .load_data_i (tx_data_i),
    .launch_i    (launch),
    .capture_i   (capture),
    .poci_i      (poci_i),
    .tx_bit_o    (tx_bit),
    .rx_next_o   (rx_next)
  );

  always_comb begin
    st_d = st_q;
    k_d  = k_q;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_RUN;
        k_d  = '0;
      end
      ST_RUN: if (tick) begin
        if (done) begin
          st_d = ST_GAP;
          k_d  = '0;
        end else if (cont) begin
          k_d = '0;
        end else begin
          k_d = knext;
        end
      end
      ST_GAP: if (tick) begin
        // minimum CS high time: one SCLK period
        if (knext == K_TWO) begin
          st_d = ST_IDLE;
          k_d  = '0;
        end else begin
          k_d = knext;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      k_q        <= '0;
      cs_q       <= 1'b1;
      sclk_q     <= 1'b0;
      pico_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      st_q <= st_d;
      k_q  <= k_d;
      cs_q <= three_wire_i ? 1'b0 : (st_d != ST_RUN);
      if (st_q != ST_RUN) sclk_q <= cpol_i;
      else if (toggle)    sclk_q <= ~sclk_q;
      if (launch) pico_q <= tx_bit;
      if (last_cap) begin
        rx_valid_q <= 1'b1;
        rx_data_q  <= rx_next;
      end else if (rx_ready_i) begin
        rx_valid_q <= 1'b0;
      end
    end
  end

  assign sclk_o     = sclk_q;
  assign pico_o     = pico_q;
  assign cs_no      = cs_q;
  assign busy_o     = (st_q == ST_RUN);
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
endmodule

// File: rtl/spi_frame_seq_chk.sv
module spi_frame_seq_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpol_i,
  input logic              three_wire_i,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              busy_o,
  input logic              cs_no,
  input logic              sclk_o,
  input logic              pico_o
);
  p_idle_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !busy_o && $past(!busy_o) && $stable(cpol_i)) |-> (sclk_o == cpol_i))
    else $error("p_idle_level_r1");

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o && !busy_o) |=> busy_o)
    else $error("p_start_r2");

  p_cs_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_no) && !three_wire_i) |=> cs_no)
    else $error("p_cs_gap_r6");

  p_pico_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(busy_o)) |-> $stable(pico_o))
    else $error("p_pico_quiet_r9");

  p_rx_push_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> busy_o)
    else $error("p_rx_push_r10");

  p_rx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i && !busy_o) |=> (rx_valid_o && $stable(rx_data_o)))
    else $error("p_rx_hold_r10");

  p_cs_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !three_wire_i && $past(!three_wire_i)) |-> (cs_no == !busy_o))
    else $error("p_cs_busy_r11");
endmodule

bind spi_frame_seq spi_frame_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_spi_frame_seq.sv
module sim_spi_frame_seq;
  localparam int W = 8;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, cpol = 0, cpha = 0, tw = 0, b2b = 0, rx_ready = 1, tx_valid = 0;
  logic [DW-1:0] div = '0;
  logic [W-1:0] tx_data = '0;
  logic tx_ready, rx_valid, sclk, pico, cs_n, busy;
  logic [W-1:0] rx_data;
  logic poci = 1'b0;

  always #4 clk = ~clk;

  spi_frame_seq #(.DATA_W(W), .DIV_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .cpha_i(cpha),
    .three_wire_i(tw), .b2b_i(b2b), .div_i(div), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .poci_i(poci),
    .sclk_o(sclk), .pico_o(pico), .cs_no(cs_n), .busy_o(busy)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done_flag = 0;
  logic [W-1:0] tx_words [8];
  logic [W-1:0] per_words [8];

  // monitor state
  bit mon_clr = 0;
  logic [W-1:0] mcap [8];
  logic [W-1:0] rxcap [8];
  logic [W-1:0] pout, pin;
  int mi, ri, edges, busy_rises, cs_falls, start_cyc, first_edge, last_cap_cyc;
  int cs_rise_cyc, bfall_cyc, min_hi, hi_start, cs_hi_samples, rx_rise_cyc, ready_seen;
  int ecnt, bcnt, pidx;
  bit fe_seen, hi_valid, psclk, pcs, pbusy, prxv;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_clr) begin
      mi = 0; ri = 0; edges = 0; busy_rises = 0; cs_falls = 0; start_cyc = 0;
      first_edge = -1; last_cap_cyc = 0; cs_rise_cyc = 0; bfall_cyc = 0;
      min_hi = 1000000; hi_start = 0; cs_hi_samples = 0; rx_rise_cyc = 0;
      ready_seen = 0; ecnt = 0; bcnt = 0; pidx = 0; fe_seen = 0; hi_valid = 0;
      pout = '0; pin = '0;
    end else begin
      if (busy && !pbusy) begin
        busy_rises++; start_cyc = cyc; fe_seen = 0; ecnt = 0; bcnt = 0;
        if (!cpha) begin
          pout = per_words[pidx & 7]; pidx++; poci = pout[W-1];
        end
      end
      if (!busy && pbusy) bfall_cyc = cyc;
      if (sclk != psclk) begin
        edges++;
        if (!fe_seen) begin first_edge = cyc - start_cyc; fe_seen = 1; end
        ecnt++;
        if (cpha ? (ecnt % 2 == 0) : (ecnt % 2 == 1)) begin
          pin = {pin[W-2:0], pico}; bcnt++; last_cap_cyc = cyc;
          if (bcnt == W) begin mcap[mi & 7] = pin; mi++; bcnt = 0; end
        end
        if (cpha) begin
          if (ecnt % 2 == 1) begin
            if (ecnt == 1) begin pout = per_words[pidx & 7]; pidx++; end
            else pout = pout << 1;
            poci = pout[W-1];
          end
        end else if (ecnt % 2 == 0 && ecnt < 2 * W) begin
          pout = pout << 1; poci = pout[W-1];
        end
        if (ecnt == 2 * W) ecnt = 0;
      end
      if (!cs_n && pcs) begin
        cs_falls++;
        if (hi_valid && (cyc - hi_start) < min_hi) min_hi = cyc - hi_start;
      end
      if (cs_n && !pcs) begin cs_rise_cyc = cyc; hi_start = cyc; hi_valid = 1; end
      if (cs_n) cs_hi_samples++;
      if (tx_ready) ready_seen++;
      if (rx_valid && !prxv) rx_rise_cyc = cyc;
      if (rx_valid && rx_ready) begin rxcap[ri & 7] = rx_data; ri++; end
    end
    psclk = sclk; pcs = cs_n; pbusy = busy; prxv = rx_valid;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    #1 mon_clr = 1;
    @(negedge clk);
    #1 mon_clr = 0;
  endtask

  task automatic send_words(input int n);
    for (int i = 0; i < n; i++) begin
      tx_data = tx_words[i];
      tx_valid = 1;
      forever begin
        #1;
        if (tx_ready) break;
        @(negedge clk);
      end
      @(negedge clk);
    end
    tx_valid = 0;
  endtask

  task automatic wait_done(input int h);
    while (busy) @(negedge clk);
    repeat (2 * h + 4) @(negedge clk);
  endtask

  task automatic set_mode(input bit pol, input bit pha, input int d);
    @(negedge clk);
    cpol = pol; cpha = pha; div = DW'(d);
    repeat (3) @(negedge clk);
    clr_mon();
  endtask

  task automatic t_reset();
    chk("R11 reset cs_no", cs_n, 1);
    chk("R11 reset busy", busy, 0);
    chk("R1 reset sclk", sclk, 0);
    chk("R10 reset rx_valid", rx_valid, 0);
    chk("R2 reset tx_ready", tx_ready, 0);
  endtask

  task automatic t_disabled();
    set_mode(1, 0, 1);
    en = 0; tx_data = 8'h5A; tx_valid = 1;
    repeat (40) @(negedge clk);
    chk("R2 no frame while disabled", busy_rises, 0);
    chk("R2 tx_ready low while disabled", ready_seen, 0);
    chk("R1 idle high with cpol=1", sclk, 1);
    tx_valid = 0;
    @(negedge clk);
    en = 1;
  endtask

  task automatic t_mode(input bit pol, input bit pha, input int d,
                        input logic [W-1:0] tw_, input logic [W-1:0] pw);
    int h = d + 1;
    set_mode(pol, pha, d);
    chk("R1 idle level before frame", sclk, pol);
    tx_words[0] = tw_; per_words[0] = pw;
    send_words(1);
    wait_done(h);
    chk("R4 PICO word at peripheral", mcap[0], tw_);
    chk("R4 POCI word received", rxcap[0], pw);
    chk("R9 edges per word", edges, 2 * W);
    chk(d == 1 ? "R3 first edge delay" : "R12 first edge delay scaled",
        first_edge, pha ? h : 2 * h);
    chk("R5 CS hold after last capture", cs_rise_cyc - last_cap_cyc, 2 * h);
    chk("R10 rx_valid on last capture", rx_rise_cyc, last_cap_cyc);
    chk("R11 busy falls with CS", bfall_cyc, cs_rise_cyc);
    chk("R1 idle level after frame", sclk, pol);
  endtask

  task automatic t_b2b(input bit pha, input bit cont, input int exp_falls, input string tag);
    int h = 2;
    b2b = cont;
    set_mode(0, pha, 1);
    for (int i = 0; i < 3; i++) begin
      tx_words[i] = 8'h11 * (i + 3); per_words[i] = 8'hC3 ^ (8'h25 * i);
    end
    send_words(3);
    wait_done(h);
    chk({tag, " CS falls"}, cs_falls, exp_falls);
    for (int i = 0; i < 3; i++) begin
      chk("R4 b2b PICO word", mcap[i], tx_words[i]);
      chk("R4 b2b POCI word", rxcap[i], per_words[i]);
    end
    chk("R9 b2b edge total", edges, 6 * W);
    if (exp_falls == 3) chk({tag, " CS high between words"}, min_hi, 2 * h + 1);
    b2b = 0;
  endtask

  task automatic t_three_wire();
    int h = 2;
    tw = 1;
    set_mode(1, 1, 1);
    tx_words[0] = 8'hE1; per_words[0] = 8'h4B;
    send_words(1);
    wait_done(h);
    chk("R8 cs_no held low", cs_hi_samples, 0);
    chk("R8 3-wire PICO word", mcap[0], 8'hE1);
    chk("R8 3-wire POCI word", rxcap[0], 8'h4B);
    chk("R11 busy span", bfall_cyc - start_cyc, (2 * W + 2) * h);
    tw = 0;
  endtask

  task automatic t_rx_stall();
    rx_ready = 0;
    set_mode(0, 0, 0);
    tx_words[0] = 8'h69; per_words[0] = 8'hB2;
    send_words(1);
    wait_done(1);
    repeat (10) @(negedge clk);
    chk("R10 rx_valid held while stalled", rx_valid, 1);
    chk("R10 rx_data held while stalled", rx_data, 8'hB2);
    rx_ready = 1;
    @(negedge clk);
    chk("R10 rx_valid cleared after ready", rx_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_disabled();
    t_mode(0, 0, 1, 8'hA5, 8'h3C);
    t_mode(0, 1, 1, 8'h96, 8'hD1);
    t_mode(1, 0, 1, 8'h4E, 8'h87);
    t_mode(1, 1, 1, 8'hC2, 8'h5B);
    t_mode(0, 0, 3, 8'h9D, 8'hE6);
    t_mode(1, 1, 3, 8'h71, 8'h1F);
    t_b2b(0, 1, 3, "R6");
    t_b2b(1, 1, 1, "R7");
    t_b2b(1, 0, 3, "R7");
    t_three_wire();
    t_rx_stall();
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule